// File: doc/BRIEF.md
# Windowed Video CRC Signature Checker

This block sits beside a parallel video pixel stream (vertical sync, horizontal sync, data-enable and 24-bit pixel data) and proves that a chosen rectangle of the picture is what it should be. It keeps a column and row position for every active pixel. It folds each pixel that lands inside the programmed rectangle into a CRC-32. When the next frame begins, it checks the finished signature against a reference value that software has written.

A small write port sets the rectangle corners, the reference signature, the region enable, a one-way lock, the active level of each sync and enable line, and the pixel capture edge. A read port returns the configuration and the signature of the last completed frame. Each compared frame ends with a one-cycle results-ready pulse. A mismatch pulse fires in the same cycle when the signature differs from the reference. Typical use is a safety monitor that confirms a warning icon or a fixed overlay really reaches the panel.

Top module: `roi_sig_checker`

## Requirements
- R1: After reset, every register reads zero: region disabled, unlocked, all three video lines active low, rising-edge capture, both corners zero, reference zero and last signature zero. Both pulse outputs are low.
- R2: The signature is a CRC-32 with generator 0x04C11DB7. It has no bit reflection and no final inversion. It restarts from 0 at every frame start and takes one whole 24-bit pixel per clock, bit 23 first.
- R3: A pixel feeds the signature only when data-enable is active and when Xul <= X <= Xlr and Yul <= Y <= Ylr. X counts active pixels since the last horizontal sync edge, starting at 0. Y starts at 0 at each frame start and steps by one at each horizontal sync edge that follows a line holding active pixels. A window with upper-left beyond lower-right takes no pixels.
- R4: Control register (address 0) bits 2, 3 and 4 give the active level of vertical sync, horizontal sync and data-enable: 1 means active high and 0 means active low.
- R5: Control bit 5 selects the capture edge: 0 means rising clock edge and 1 means falling clock edge. Both settings give the same result and the same latency.
- R6: A frame ends at the next active-going vertical sync edge. If a frame was in progress and the region is enabled, then two clocks after the first active vertical sync sample the block raises a one-cycle results-ready pulse and stores the signature for reading at address 4. If the signature differs from the reference (address 3), the mismatch pulse fires in the same cycle. The first vertical sync after reset compares nothing.
- R7: A reference write that lands in the same cycle as a frame-end compare is not used for that compare. The compare uses the old reference, and the new value applies from the next frame.
- R8: While the region is enabled (control bit 0), writes to the corner registers are ignored. The upper-left corner is at address 1 and the lower-right corner at address 2, each with X in bits 12:0 and Y in bits 27:16.
- R9: Writing 1 to control bit 1 sets the lock, and only reset clears it. While locked, the enable bit and both corners keep their values. The reference and the polarity and edge bits stay writable.
- R10: While the region is disabled, no results-ready or mismatch pulse appears and the stored last signature does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| vid_vsync | input | 1 | Vertical sync, level set by control bit 2 |
| vid_hsync | input | 1 | Horizontal sync, level set by control bit 3 |
| vid_de | input | 1 | Data enable, level set by control bit 4 |
| vid_data | input | 24 | Pixel data |
| frame_done | output | 1 | One-cycle results-ready pulse |
| crc_mismatch | output | 1 | One-cycle signature mismatch pulse |

## Verification
The frame-end compare and a reference-register write can fall in the same clock. The bench provokes this by issuing the reference write during the second vertical sync cycle of a frame, which lines up the write with the compare edge. It judges the result by expecting no mismatch on that frame, where the old reference matches. The following frame, carrying identical pixels, must then report a mismatch against the new reference.

// File: rtl/roi_pkg.sv
package roi_pkg;

    localparam int X_W    = 13;
    localparam int Y_W    = 12;
    localparam int PIX_W  = 24;
    localparam int CRC_W  = 32;
    localparam int REG_AW = 3;
    localparam int REG_DW = 32;
    localparam int Y_LSB  = 16;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

    // control register bit positions
    localparam int CB_EN   = 0;
    localparam int CB_LOCK = 1;
    localparam int CB_VSHI = 2;
    localparam int CB_HSHI = 3;
    localparam int CB_DEHI = 4;
    localparam int CB_FALL = 5;

    localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] RA_ULC  = 3'd1;
    localparam logic [REG_AW-1:0] RA_LRC  = 3'd2;
    localparam logic [REG_AW-1:0] RA_REF  = 3'd3;
    localparam logic [REG_AW-1:0] RA_SIG  = 3'd4;

    typedef struct packed {
        logic             en;
        logic             lock;
        logic             vs_hi;
        logic             hs_hi;
        logic             de_hi;
        logic             fall;
        logic [X_W-1:0]   ulx;
        logic [Y_W-1:0]   uly;
        logic [X_W-1:0]   lrx;
        logic [Y_W-1:0]   lry;
        logic [CRC_W-1:0] ref_sig;
    } roi_cfg_t;

    // video sample, sync and enable already normalised to active high
    typedef struct packed {
        logic             vs;
        logic             hs;
        logic             de;
        logic [PIX_W-1:0] pix;
    } roi_smp_t;

    // one whole pixel folded into the CRC, most significant bit first
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                  input logic [PIX_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = PIX_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
            else                   r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/roi_cfg_regs.sv
module roi_cfg_regs
    import roi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output roi_cfg_t          cfg
);

    roi_cfg_t cfg_d, cfg_q;
    logic     geom_open;

    always_comb begin
        cfg_d     = cfg_q;
        geom_open = !cfg_q.en && !cfg_q.lock;
        if (wr_en) begin
            case (wr_addr)
                RA_CTRL: begin
                    cfg_d.vs_hi = wr_data[CB_VSHI];
                    cfg_d.hs_hi = wr_data[CB_HSHI];
                    cfg_d.de_hi = wr_data[CB_DEHI];
                    cfg_d.fall  = wr_data[CB_FALL];
                    cfg_d.lock  = cfg_q.lock | wr_data[CB_LOCK];
                    if (!cfg_q.lock) cfg_d.en = wr_data[CB_EN];
                end
                RA_ULC: begin
                    if (geom_open) begin
                        cfg_d.ulx = wr_data[X_W-1:0];
                        cfg_d.uly = wr_data[Y_LSB +: Y_W];
                    end
                end
                RA_LRC: begin
                    if (geom_open) begin
                        cfg_d.lrx = wr_data[X_W-1:0];
                        cfg_d.lry = wr_data[Y_LSB +: Y_W];
                    end
                end
                RA_REF:  cfg_d.ref_sig = wr_data[CRC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/roi_pix_capture.sv
module roi_pix_capture
    import roi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_hi,
    input  logic             hs_hi,
    input  logic             de_hi,
    input  logic             fall,
    input  logic             vs_raw,
    input  logic             hs_raw,
    input  logic             de_raw,
    input  logic [PIX_W-1:0] pix_raw,
    output roi_smp_t         smp
);

    roi_smp_t nrm;
    roi_smp_t pos_d, pos_q;
    roi_smp_t neg_d, neg_q;
    roi_smp_t ret_d, ret_q;

    always_comb begin
        nrm.vs  = vs_raw ~^ vs_hi;
        nrm.hs  = hs_raw ~^ hs_hi;
        nrm.de  = de_raw ~^ de_hi;
        nrm.pix = pix_raw;
        pos_d   = nrm;
        neg_d   = nrm;
        ret_d   = neg_q;
    end

    // falling-edge capture, retimed so both paths have equal latency
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= '0;
        else        neg_q <= neg_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            ret_q <= '0;
        end else begin
            pos_q <= pos_d;
            ret_q <= ret_d;
        end
    end

    assign smp = fall ? ret_q : pos_q;

endmodule

// File: rtl/roi_frame_core.sv
module roi_frame_core
    import roi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [X_W-1:0]   ulx,
    input  logic [Y_W-1:0]   uly,
    input  logic [X_W-1:0]   lrx,
    input  logic [Y_W-1:0]   lry,
    input  logic [CRC_W-1:0] ref_sig,
    input  roi_smp_t         smp,
    output logic             frame_done,
    output logic             crc_mismatch,
    output logic [CRC_W-1:0] last_sig
);

    typedef struct packed {
        logic             vs_prev;
        logic             hs_prev;
        logic             in_frame;
        logic             line_act;
        logic [X_W-1:0]   x;
        logic [Y_W-1:0]   y;
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] last;
        logic             done;
        logic             mism;
    } core_st_t;

    core_st_t       st_d, st_q;
    logic           vs_edge, hs_edge, in_win;
    logic [X_W-1:0] x_cur;
    logic [Y_W-1:0] y_cur;

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.mism    = 1'b0;
        st_d.vs_prev = smp.vs;
        st_d.hs_prev = smp.hs;

        vs_edge = smp.vs && !st_q.vs_prev;
        hs_edge = smp.hs && !st_q.hs_prev;
        x_cur   = hs_edge ? '0 : st_q.x;
        y_cur   = st_q.y;
        if (hs_edge && st_q.line_act && (st_q.y != '1)) y_cur = st_q.y + 1'b1;
        in_win  = (x_cur >= ulx) && (x_cur <= lrx) && (y_cur >= uly) && (y_cur <= lry);

        if (vs_edge) begin
            if (st_q.in_frame && en) begin
                st_d.last = st_q.crc;
                st_d.done = 1'b1;
                st_d.mism = (st_q.crc != ref_sig);
            end
            st_d.crc      = '0;
            st_d.x        = '0;
            st_d.y        = '0;
            st_d.line_act = 1'b0;
            st_d.in_frame = 1'b1;
        end else begin
            if (hs_edge) begin
                st_d.x        = '0;
                st_d.y        = y_cur;
                st_d.line_act = 1'b0;
            end
            if (smp.de && !smp.vs) begin
                st_d.y        = y_cur;
                st_d.line_act = 1'b1;
                if (x_cur != '1) st_d.x = x_cur + 1'b1;
                if (en && st_q.in_frame && in_win) st_d.crc = crc_fold(st_q.crc, smp.pix);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_done   = st_q.done;
    assign crc_mismatch = st_q.mism;
    assign last_sig     = st_q.last;

endmodule

// File: rtl/roi_sig_checker.sv
module roi_sig_checker
    import roi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    input  logic              vid_vsync,
    input  logic              vid_hsync,
    input  logic              vid_de,
    input  logic [PIX_W-1:0]  vid_data,
    output logic              frame_done,
    output logic              crc_mismatch
);

    roi_cfg_t         cfg;
    roi_smp_t         smp;
    logic [CRC_W-1:0] last_sig;
    logic             cfg_en, cfg_lock;
    logic [X_W-1:0]   cfg_ulx, cfg_lrx;
    logic [Y_W-1:0]   cfg_uly, cfg_lry;

    assign cfg_en   = cfg.en;
    assign cfg_lock = cfg.lock;
    assign cfg_ulx  = cfg.ulx;
    assign cfg_uly  = cfg.uly;
    assign cfg_lrx  = cfg.lrx;
    assign cfg_lry  = cfg.lry;

    roi_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    roi_pix_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .vs_hi   (cfg.vs_hi),
        .hs_hi   (cfg.hs_hi),
        .de_hi   (cfg.de_hi),
        .fall    (cfg.fall),
        .vs_raw  (vid_vsync),
        .hs_raw  (vid_hsync),
        .de_raw  (vid_de),
        .pix_raw (vid_data),
        .smp     (smp)
    );

    roi_frame_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (cfg_en),
        .ulx          (cfg_ulx),
        .uly          (cfg_uly),
        .lrx          (cfg_lrx),
        .lry          (cfg_lry),
        .ref_sig      (cfg.ref_sig),
        .smp          (smp),
        .frame_done   (frame_done),
        .crc_mismatch (crc_mismatch),
        .last_sig     (last_sig)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL: begin
                rd_data[CB_EN]   = cfg_en;
                rd_data[CB_LOCK] = cfg_lock;
                rd_data[CB_VSHI] = cfg.vs_hi;
                rd_data[CB_HSHI] = cfg.hs_hi;
                rd_data[CB_DEHI] = cfg.de_hi;
                rd_data[CB_FALL] = cfg.fall;
            end
            RA_ULC: begin
                rd_data[X_W-1:0]     = cfg_ulx;
                rd_data[Y_LSB +: Y_W] = cfg_uly;
            end
            RA_LRC: begin
                rd_data[X_W-1:0]     = cfg_lrx;
                rd_data[Y_LSB +: Y_W] = cfg_lry;
            end
            RA_REF:  rd_data = cfg.ref_sig;
            RA_SIG:  rd_data = last_sig;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/roi_sig_checker_chk.sv
module roi_sig_checker_chk
    import roi_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             lock,
    input logic [X_W-1:0]   ulx,
    input logic [Y_W-1:0]   uly,
    input logic [X_W-1:0]   lrx,
    input logic [Y_W-1:0]   lry,
    input logic [CRC_W-1:0] sig,
    input logic             done,
    input logic             mism
);

    // R6
    mism_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mism |-> done);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    sig_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sig) |-> done);

    // R8
    geom_frozen_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ($stable(ulx) && $stable(uly) && $stable(lrx) && $stable(lry)));

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R9
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(en) && $stable(ulx) && $stable(uly) && $stable(lrx) && $stable(lry)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!done && !mism && $stable(sig)));

endmodule

bind roi_sig_checker roi_sig_checker_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cfg_en),
    .lock  (cfg_lock),
    .ulx   (cfg_ulx),
    .uly   (cfg_uly),
    .lrx   (cfg_lrx),
    .lry   (cfg_lry),
    .sig   (last_sig),
    .done  (frame_done),
    .mism  (crc_mismatch)
);

// File: tb/sim_roi_sig_checker.sv
module sim_roi_sig_checker;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [12:0] ulx;
        logic [11:0] uly;
        logic [12:0] lrx;
        logic [11:0] lry;
        logic [3:0]  w;
        logic [3:0]  l;
        logic [3:0]  pol;   // [3] vs high, [2] hs high, [1] de high, [0] falling capture
        logic        match;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{13'd2,    12'd1,    13'd5,    12'd3, 4'd8, 4'd5, 4'b0000, 1'b1, 8'h11},
        '{13'd2,    12'd1,    13'd5,    12'd3, 4'd8, 4'd5, 4'b0000, 1'b0, 8'h22},
        '{13'd0,    12'd0,    13'd8191, 12'd4095, 4'd8, 4'd4, 4'b1111, 1'b1, 8'h33},
        '{13'd3,    12'd2,    13'd3,    12'd2, 4'd6, 4'd4, 4'b1010, 1'b0, 8'h44},
        '{13'd20,   12'd0,    13'd30,   12'd3, 4'd8, 4'd3, 4'b0101, 1'b1, 8'h55},
        '{13'd6,    12'd3,    13'd1,    12'd0, 4'd8, 4'd4, 4'b0011, 1'b0, 8'h66}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        vid_vsync, vid_hsync, vid_de;
    logic [23:0] vid_data;
    logic        frame_done, crc_mismatch;

    int   n_chk  = 0;
    int   n_fail = 0;
    int   done_cnt = 0;
    logic [3:0] cur_pol = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    roi_sig_checker u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .vid_vsync    (vid_vsync),
        .vid_hsync    (vid_hsync),
        .vid_de       (vid_de),
        .vid_data     (vid_data),
        .frame_done   (frame_done),
        .crc_mismatch (crc_mismatch)
    );

    always @(negedge clk) if (frame_done === 1'b1) done_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drv(input logic vs, input logic hs, input logic de, input logic [23:0] d);
        vid_vsync = cur_pol[3] ? vs : ~vs;
        vid_hsync = cur_pol[2] ? hs : ~hs;
        vid_de    = cur_pol[1] ? de : ~de;
        vid_data  = d;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
        rd_addr = 3'd4;
    endtask

    function automatic logic [23:0] pix(input logic [7:0] s, input int x, input int y);
        logic [3:0] xs = 4'(x);
        logic [3:0] ys = 4'(y);
        return {s, ys, xs, s ^ {xs, ys}};
    endfunction

    function automatic logic [31:0] model_sig(input vec_t v);
        logic [31:0] c = 32'h0;
        for (int y = 0; y < int'(v.l); y++)
            for (int x = 0; x < int'(v.w); x++)
                if (x >= int'(v.ulx) && x <= int'(v.lrx) && y >= int'(v.uly) && y <= int'(v.lry)) begin
                    logic [23:0] d = pix(v.seed, x, y);
                    for (int b = 23; b >= 0; b--) begin
                        logic fb = c[31] ^ d[b];
                        c = {c[30:0], 1'b0};
                        if (fb) c = c ^ 32'h04C11DB7;
                    end
                end
        return c;
    endfunction

    function automatic logic [31:0] ctrl_word(input logic [3:0] p, input logic en, input logic lk);
        return {26'b0, p[0], p[1], p[2], p[3], lk, en};
    endfunction

    // vertical sync, optional compare check, then lines of pixels
    task automatic vframe(input int w, input int l, input logic [7:0] seed,
                          input bit chk_en, input logic exp_m, input logic [31:0] exp_sig,
                          input bit rw_en, input logic [31:0] rw_val, input string tag);
        step();
        drv(1, 0, 0, 24'h0);
        step();
        if (rw_en) begin
            wr_en = 1'b1; wr_addr = 3'd3; wr_data = rw_val;
        end
        step();
        wr_en = 1'b0;
        if (chk_en) begin
            chk({"R6 done ", tag}, {31'b0, frame_done}, 32'd1);
            chk({"R6 mismatch ", tag}, {31'b0, crc_mismatch}, {31'b0, exp_m});
        end
        drv(0, 0, 0, 24'h0);
        step();
        if (chk_en) begin
            chk({"R6 pulse width ", tag}, {31'b0, frame_done}, 32'd0);
            rd_chk({"R2 R3 R4 R5 signature ", tag}, 3'd4, exp_sig);
        end
        for (int y = 0; y < l; y++) begin
            drv(0, 1, 0, 24'h0);
            step();
            drv(0, 0, 0, 24'h0);
            for (int x = 0; x < w; x++) begin
                step();
                drv(0, 0, 1, pix(seed, x, y));
            end
            step();
            drv(0, 0, 0, 24'h0);
        end
    endtask

    task automatic setup(input vec_t v, input logic [31:0] refv);
        wr(3'd0, ctrl_word(v.pol, 1'b0, 1'b0));
        cur_pol = v.pol;
        drv(0, 0, 0, 24'h0);
        repeat (3) step();
        wr(3'd1, {4'b0, v.uly, 3'b0, v.ulx});
        wr(3'd2, {4'b0, v.lry, 3'b0, v.lrx});
        wr(3'd3, refv);
        wr(3'd0, ctrl_word(v.pol, 1'b1, 1'b0));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cur_pol = 4'b0000;
        drv(0, 0, 0, 24'h0);
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t        v;
        logic [31:0] e, s0;
        int          c0;
        wr_en = 1'b0; wr_addr = 3'd0; wr_data = 32'h0; rd_addr = 3'd4;
        do_reset();

        // R1 reset state
        chk("R1 done low", {31'b0, frame_done}, 32'd0);
        chk("R1 mismatch low", {31'b0, crc_mismatch}, 32'd0);
        rd_chk("R1 ctrl", 3'd0, 32'h0);
        rd_chk("R1 upper-left", 3'd1, 32'h0);
        rd_chk("R1 reference", 3'd3, 32'h0);
        rd_chk("R1 signature", 3'd4, 32'h0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            e = model_sig(v);
            setup(v, v.match ? e : (e ^ 32'h1));
            vframe(int'(v.w), int'(v.l), v.seed, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "start");
            vframe(0, 0, v.seed, 1'b1, !v.match, e, 1'b0, 32'h0, $sformatf("vec%0d", i));
        end

        // R8 corner write ignored while enabled (vector 5 geometry still in place)
        wr(3'd1, 32'h0005_0007);
        rd_chk("R8 upper-left held", 3'd1, 32'h0003_0006);

        // R7 reference write coinciding with compare
        v = '{13'd0, 12'd0, 13'd7, 12'd4, 4'd8, 4'd5, 4'b0000, 1'b1, 8'h77};
        e = model_sig(v);
        setup(v, e);
        vframe(8, 5, 8'h77, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "r7 start");
        vframe(8, 5, 8'h77, 1'b1, 1'b0, e, 1'b1, e ^ 32'hFF, "R7 old reference");
        vframe(0, 0, 8'h77, 1'b1, 1'b1, e, 1'b0, 32'h0, "R7 new reference");

        // R10 disabled region stays quiet
        wr(3'd0, ctrl_word(cur_pol, 1'b0, 1'b0));
        rd_addr = 3'd4; #1; s0 = rd_data;
        c0 = done_cnt;
        vframe(8, 3, 8'h88, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "off1");
        vframe(8, 3, 8'h99, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "off2");
        vframe(0, 0, 8'h99, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "off3");
        step();
        chk("R10 no result pulses", 32'(done_cnt), 32'(c0));
        rd_chk("R10 signature kept", 3'd4, s0);

        // R9 lock
        wr(3'd0, ctrl_word(cur_pol, 1'b1, 1'b0));
        wr(3'd0, ctrl_word(cur_pol, 1'b1, 1'b1));
        wr(3'd0, 32'h0000_0004);
        rd_chk("R9 ctrl locked, polarity writable", 3'd0, 32'h0000_0007);
        wr(3'd1, 32'h0002_0003);
        rd_chk("R9 corner held", 3'd1, 32'h0);
        wr(3'd3, 32'hDEAD_BEEF);
        rd_chk("R9 reference writable", 3'd3, 32'hDEAD_BEEF);

        // R1 lock cleared only by reset
        do_reset();
        rd_chk("R1 ctrl after second reset", 3'd0, 32'h0);
        rd_chk("R1 reference after second reset", 3'd3, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule